// File: doc/BRIEF.md
# DDR Write Burst Strobe Sequencer

This block produces the controller side of one write burst to a DDR SDRAM. It runs on an internal clock at twice the memory clock rate, so each tick is one half of a memory clock. When it is idle it takes a request made of a bank, a column and an auto-precharge flag. It issues the write command with its address, then drives the data strobe through its low preamble, one strobe edge for each data beat, and a low postamble. It then releases the strobe. The block also produces the output enables for the strobe, data and mask tri-states.

Data is fetched from a source through a pull strobe. In the tick before each beat the block asserts `beat_rd` and shows the column of that beat on `beat_col`. The source answers on `wr_data`/`wr_mask` in the same tick, and the block registers that word onto the data pins. Burst length and burst order come from configuration inputs and are captured when the request is accepted.

Top module: `ddr_wr_burst_seq`

## Requirements
- R1: A request (`req_valid`=1) is accepted at a clock edge when the block is idle and `cfg_bl` is nonzero. The write command (cs_n=0, ras_n=1, cas_n=0, we_n=0) is shown for the two ticks that follow acceptance (ticks 1 and 2). Every other tick carries NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1).
- R2: During the command ticks, `cmd_ba` equals the bank, `cmd_addr[COL_W-1:0]` equals the column, `cmd_addr[10]` equals the auto-precharge flag and all other address bits are 0. Outside the command ticks, `cmd_ba` and `cmd_addr` are 0.
- R3: The strobe preamble occupies tick 2, with `dqs_oe`=1, `dqs_out`=0 and `dq_oe`=0.
- R4: Beat k (k=0..N-1) occupies tick 3+k, with `dq_oe`=1 and `dqs_out`=1 for even k and 0 for odd k. `dq_out` carries the `wr_data` that was present in the tick when `beat_rd` was 1 for that beat (tick 2+k). Outside beats, `dq_out` is 0.
- R5: The postamble occupies tick N+3, with `dqs_oe`=1, `dqs_out`=0 and `dq_oe`=0. From tick N+4 onwards `dqs_oe` is 0.
- R6: The burst length N is set by `cfg_bl` as follows: 01 gives 2, 10 gives 4 and 11 gives 8. A request made while `cfg_bl`=00 is ignored.
- R7: With `cfg_interleave`=0, beat k uses column ((col + k) mod N) in its low log2(N) bits. The upper bits are those of the request column.
- R8: With `cfg_interleave`=1, beat k uses column (col XOR k) in its low log2(N) bits. The upper bits are those of the request column.
- R9: `busy` is 1 from tick 1 through tick N+3, and a request made while busy is ignored.
- R10: Burst length, order, column, bank and flag are captured at acceptance. Changing them during a burst has no effect on that burst.
- R11: While in reset and after reset, the outputs show NOP, all output enables are 0 and `busy` is 0.
- R12: `dm_out` carries `wr_mask` per beat with the same timing as the data, and `dm_oe` equals `dq_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate internal clock, one tick per memory half-cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request |
| req_bank | input | 2 | Bank of the request |
| req_col | input | COL_W | Starting column |
| req_autopre | input | 1 | Auto-precharge flag |
| cfg_bl | input | 2 | Burst length code |
| cfg_interleave | input | 1 | 1 selects interleaved order |
| busy | output | 1 | Burst in progress |
| beat_rd | output | 1 | Pull strobe to the data source |
| beat_col | output | COL_W | Column of the beat being fetched |
| wr_data | input | DQ_W | Data word from the source |
| wr_mask | input | DM_W | Mask bits from the source |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 2 | Bank select |
| cmd_addr | output | ADDR_W | Address pins |
| dqs_out | output | 1 | Data strobe level |
| dqs_oe | output | 1 | Data strobe output enable |
| dq_out | output | DQ_W | Data pins |
| dq_oe | output | 1 | Data output enable |
| dm_out | output | DM_W | Mask pins |
| dm_oe | output | 1 | Mask output enable |

## Verification
The strobe preamble is placed in the second half of the write command, so in tick 2 the command decode and the strobe enable are both active. Every burst in the table is walked tick by tick, and both are compared in the same sample. A second collision occurs when a new request with a different configuration is held during a running burst. It is judged by checking that the running burst keeps its original order, length and address, and that no second command appears before the postamble ends.

// File: rtl/ddr_wr_burst_seq.sv
module ddr_wr_burst_seq #(
  parameter int DQ_W   = 16,
  parameter int DM_W   = DQ_W / 8,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_autopre,
  input  logic [1:0]        cfg_bl,
  input  logic              cfg_interleave,
  output logic              busy,
  output logic              beat_rd,
  output logic [COL_W-1:0]  beat_col,
  input  logic [DQ_W-1:0]   wr_data,
  input  logic [DM_W-1:0]   wr_mask,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [1:0]        cmd_ba,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              dqs_out,
  output logic              dqs_oe,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic [DM_W-1:0]   dm_out,
  output logic              dm_oe
);
  localparam int AP_BIT = 10;

  logic [3:0]       cnt, blen;
  logic             ilv, ap;
  logic [1:0]       ba;
  logic [COL_W-1:0] col;
  logic [DQ_W-1:0]  dq_r;
  logic [DM_W-1:0]  dm_r;
  logic [2:0]       rd_k, wmask, off;
  logic [ADDR_W-1:0] addr_w;

  wire accept = req_valid && (cnt == 4'd0) && (cfg_bl != 2'b00);
  wire is_cmd = (cnt == 4'd1) || (cnt == 4'd2);
  wire in_beat = (cnt >= 4'd3) && (cnt <= blen + 4'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      blen <= 4'd2;
      ilv  <= 1'b0;
      ap   <= 1'b0;
      ba   <= '0;
      col  <= '0;
    end else if (accept) begin
      cnt  <= 4'd1;
      blen <= 4'd1 << cfg_bl;
      ilv  <= cfg_interleave;
      ap   <= req_autopre;
      ba   <= req_bank;
      col  <= req_col;
    end else if (cnt != 4'd0) begin
      cnt <= (cnt == blen + 4'd3) ? 4'd0 : cnt + 4'd1;
    end
  end

  assign busy    = cnt != 4'd0;
  assign beat_rd = (cnt >= 4'd2) && (cnt <= blen + 4'd1);
  assign rd_k    = 3'(cnt - 4'd2);
  assign wmask   = blen[2:0] - 3'd1;
  assign off     = ilv ? (col[2:0] ^ rd_k) : (col[2:0] + rd_k);
  assign beat_col = beat_rd ? {col[COL_W-1:3], (col[2:0] & ~wmask) | (off & wmask)} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_r <= '0;
      dm_r <= '0;
    end else if (beat_rd) begin
      dq_r <= wr_data;
      dm_r <= wr_mask;
    end
  end

  always_comb begin
    addr_w = '0;
    addr_w[COL_W-1:0] = col;
    addr_w[AP_BIT] = ap;
  end

  assign cmd_cs_n  = 1'b0;
  assign cmd_ras_n = 1'b1;
  assign cmd_cas_n = !is_cmd;
  assign cmd_we_n  = !is_cmd;
  assign cmd_ba    = is_cmd ? ba : 2'b00;
  assign cmd_addr  = is_cmd ? addr_w : '0;

  assign dqs_oe  = (cnt >= 4'd2) && (cnt <= blen + 4'd3);
  assign dqs_out = in_beat && cnt[0];
  assign dq_oe   = in_beat;
  assign dm_oe   = in_beat;
  assign dq_out  = in_beat ? dq_r : '0;
  assign dm_out  = in_beat ? dm_r : '0;

  // R1
  cmd_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_cas_n |-> busy);
  // R9
  cmd_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_we_n) |-> $past(!busy));
  // R3
  preamble_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dqs_oe) |-> (!dqs_out && !dq_oe && !cmd_we_n));
  // R4
  dq_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> dqs_oe);
  // R4
  strobe_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> (dqs_out != $past(dqs_out)));
  // R5
  postamble_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> (dqs_oe && !dqs_out));
  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !dqs_oe);
  // R12
  dm_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dm_oe == dq_oe);
endmodule

// File: tb/test_ddr_wr_burst_seq.sv
`timescale 1ns/1ps
module test_ddr_wr_burst_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_autopre = 1'b0, cfg_interleave = 1'b0;
  logic [1:0] req_bank = '0, cfg_bl = 2'd1;
  logic [8:0] req_col = '0;
  logic busy, beat_rd;
  logic [8:0] beat_col;
  logic [15:0] wr_data;
  logic [1:0] wr_mask;
  logic cs_n, ras_n, cas_n, we_n, dqs_out, dqs_oe, dq_oe, dm_oe;
  logic [1:0] ba, dm_out;
  logic [12:0] addr;
  logic [15:0] dq_out;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] dfun(input logic [8:0] c); return {7'h5A, c}; endfunction
  function automatic logic [1:0] mfun(input logic [8:0] c); return c[1:0] ^ 2'b01; endfunction
  function automatic logic [8:0] ecol(input logic [8:0] c, input int n, input logic il, input int k);
    logic [8:0] m = 9'(n - 1);
    return (c & ~m) | ((il ? (c ^ 9'(k)) : (c + 9'(k))) & m);
  endfunction

  assign wr_data = dfun(beat_col);
  assign wr_mask = mfun(beat_col);

  ddr_wr_burst_seq i_ddr_wr_burst_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_col(req_col), .req_autopre(req_autopre), .cfg_bl(cfg_bl),
    .cfg_interleave(cfg_interleave), .busy(busy), .beat_rd(beat_rd),
    .beat_col(beat_col), .wr_data(wr_data), .wr_mask(wr_mask),
    .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
    .cmd_ba(ba), .cmd_addr(addr), .dqs_out(dqs_out), .dqs_oe(dqs_oe),
    .dq_out(dq_out), .dq_oe(dq_oe), .dm_out(dm_out), .dm_oe(dm_oe));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // {bl, ilv, ap, bank, col, last column}
  localparam logic [23:0] VEC [8] = '{
    {2'd1, 1'b0, 1'b0, 2'd0, 9'h000, 9'h001},
    {2'd1, 1'b1, 1'b0, 2'd1, 9'h0A3, 9'h0A2},
    {2'd2, 1'b0, 1'b0, 2'd2, 9'h016, 9'h015},
    {2'd2, 1'b1, 1'b1, 2'd3, 9'h015, 9'h016},
    {2'd3, 1'b0, 1'b0, 2'd1, 9'h1FD, 9'h1FC},
    {2'd3, 1'b1, 1'b0, 2'd0, 9'h1FD, 9'h1FA},
    {2'd3, 1'b0, 1'b1, 2'd3, 9'h100, 9'h107},
    {2'd2, 1'b0, 1'b1, 2'd2, 9'h0FF, 9'h0FE}
  };

  // called at a negedge; returns at the negedge of tick N+4
  task automatic run_burst(input logic [1:0] bl, input logic il, input logic ap,
                           input logic [1:0] bk, input logic [8:0] c,
                           input logic [8:0] last, input bit disturb);
    int n = 1 << bl;
    req_valid = 1'b1; cfg_bl = bl; cfg_interleave = il;
    req_autopre = ap; req_bank = bk; req_col = c;
    @(posedge clk);
    for (int t = 1; t <= n + 4; t++) begin
      logic ewr, eqs, edq, edqs, eb;
      logic [8:0] ec;
      @(negedge clk);
      ewr = (t == 1) || (t == 2);
      eqs = (t >= 2) && (t <= n + 3);
      edq = (t >= 3) && (t <= n + 2);
      edqs = edq && t[0];
      eb = (t >= 1) && (t <= n + 3);
      // R1 R3 R4 R5 R9 R12 control timing
      check("R1/R3/R4/R5/R9 ctrl", {23'd0, busy, cs_n, ras_n, cas_n, we_n, dqs_oe, dqs_out, dq_oe, dm_oe},
            {23'd0, eb, 1'b0, 1'b1, !ewr, !ewr, eqs, edqs, edq, edq});
      // R2 address
      check("R2 addr", {17'd0, ba, addr}, ewr ? {17'd0, bk, 13'(c) | (13'(ap) << 10)} : 32'd0);
      // R4 R7 R8 R12 data, mask, order
      ec = edq ? ecol(c, n, il, t - 3) : 9'd0;
      check("R4/R7/R8/R12 data", {14'd0, dm_out, dq_out}, edq ? {14'd0, mfun(ec), dfun(ec)} : 32'd0);
      if (t == n + 2) check("R6/R7/R8 last beat", {16'd0, dq_out}, {16'd0, dfun(last)});
      if (t == 1) begin
        if (disturb) begin
          // R10 R9 new request and config during burst
          cfg_bl = 2'd3 - bl + 2'd1; cfg_interleave = !il; req_col = ~c; req_bank = ~bk; req_autopre = !ap;
        end else req_valid = 1'b0;
      end
      if (t == n + 2) req_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset", {26'd0, busy, cas_n, we_n, dqs_oe, dq_oe, dm_oe}, {26'd0, 6'b011000});
    req_valid = 1'b1;
    @(negedge clk);
    check("R11 reset ignores req", {30'd0, busy, cas_n}, 32'd1);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after reset", {26'd0, busy, cas_n, we_n, dqs_oe, dq_oe, dm_oe}, {26'd0, 6'b011000});
    foreach (VEC[i])
      run_burst(VEC[i][23:22], VEC[i][21], VEC[i][20], VEC[i][19:18], VEC[i][17:9], VEC[i][8:0], 1'b0);
    // R6 code 00 ignored
    req_valid = 1'b1; cfg_bl = 2'd0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R6 bl=00 ignored", {29'd0, busy, cas_n, dqs_oe}, {29'd0, 3'b010});
    end
    req_valid = 1'b0;
    // R9 R10 request held during burst with a different configuration
    run_burst(2'd2, 1'b0, 1'b0, 2'd1, 9'h015, 9'h014, 1'b1);
    check("R9 no second command", {30'd0, busy, cas_n}, 32'd1);
    run_burst(2'd1, 1'b1, 1'b1, 2'd3, 9'h1FF, 9'h1FE, 1'b1);
    // back-to-back after idle
    run_burst(2'd3, 1'b1, 1'b0, 2'd2, 9'h042, 9'h045, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule